// File: doc/BRIEF.md
# Limp-Home Fail-Safe Controller

This controller sits beside the serial register interface of a two-channel load switch. It chooses between two modes. In the active mode each channel enable follows the command from normal operation. In the limp-home mode both channel enables go to a predefined safe pattern, and register writes from the serial interface are held back. Either of two events starts limp-home: a system controller raises an external request pin, or the serial interface stays silent for too long and the internal watchdog expires.

The safe pattern comes from a 2-bit field that the register file supplies. When that field is zero, a strap pin picks the pattern instead: the pin high turns both channels on, and the pin low turns both off. A channel still charging a capacitive load keeps its charging sequence only if the safe pattern leaves it on. To leave limp-home, the host must first release the request pin and then write a one to the status bit at its register address.

Top module: `limp_home_ctrl`

## Requirements
- R1: After reset the controller is in the active mode with `lh_stat` low. The watchdog is loaded with its full count.
- R2: `req_pin` is resynchronised through two flops. A rising level on it sets `lh_stat` on the third rising clock edge after the change.
- R3: If `WD_CYCLES` clock edges pass in the active mode with no `spi_strobe`, `lh_stat` is set. Every `spi_strobe` reloads the full count.
- R4: In limp-home, `lh_field` bit 0 drives channel 1 (`ch_en[0]`) and bit 1 drives channel 2 (`ch_en[1]`). So 01 gives channel 1 only, 10 gives channel 2 only, and 11 gives both.
- R5: In limp-home with `lh_field` = 00, both bits of `ch_en` equal the resynchronised `dflt_pin`.
- R6: `reg_wr_en` equals `spi_strobe & spi_wr` in the active mode and is 0 whenever `lh_stat` is high.
- R7: `lh_stat` clears at the clock edge that samples an exit write. An exit write is `spi_strobe` and `spi_wr` high, `spi_addr` = `STAT_ADDR`, and `spi_data` bit `STAT_BIT` = 1, while the resynchronised request is low. A write to that address with the bit at 0 does not exit.
- R8: An exit write made while the resynchronised request is still high is ignored, and `lh_stat` stays high.
- R9: `chg_keep[i]` = `chg_busy[i] & ch_en[i]`. In limp-home, a charging channel whose safe state is off has `ch_en[i]` = 0 at once.
- R10: The watchdog does not count during limp-home and is reloaded on exit. After an exit, a full `WD_CYCLES` of silence is needed before it re-enters.
- R11: In the active mode `ch_en` equals `cmd_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pin | input | 1 | External limp-home request (asynchronous) |
| dflt_pin | input | 1 | Default safe-state strap (asynchronous) |
| spi_strobe | input | 1 | One-cycle pulse per completed serial frame |
| spi_wr | input | 1 | Frame is a register write |
| spi_addr | input | ADDR_W | Register write address |
| spi_data | input | DATA_W | Register write data |
| lh_field | input | 2 | Safe-state field from the status register |
| cmd_on | input | 2 | Channel commands from normal operation |
| chg_busy | input | 2 | Per-channel capacitive charging in progress |
| ch_en | output | 2 | Channel enables |
| chg_keep | output | 2 | Continue the charging sequence on a channel |
| lh_stat | output | 1 | Limp-home status |
| reg_wr_en | output | 1 | Register-file write enable |

## Verification
The channel enables, `chg_keep` and `reg_wr_en` are combinational from inputs and the mode flop, so the bench samples them one time step after driving inputs. The exceptions are changes to `dflt_pin`, which pass through two synchroniser flops, so the bench waits three clock edges before checking. Mode changes caused by the request pin are due on the third edge. Mode changes caused by an exit write are due on the edge that samples the strobe. Watchdog expiry is checked on both sides of the `WD_CYCLES` boundary. All samples are taken on the falling edge, away from the active edge.

// File: rtl/limp_home_ctrl.sv
module limp_home_ctrl #(
  parameter int WD_CYCLES = 100000,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 12,
  parameter int STAT_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_pin,
  input  logic              dflt_pin,
  input  logic              spi_strobe,
  input  logic              spi_wr,
  input  logic [ADDR_W-1:0] spi_addr,
  input  logic [DATA_W-1:0] spi_data,
  input  logic [1:0]        lh_field,
  input  logic [1:0]        cmd_on,
  input  logic [1:0]        chg_busy,
  output logic [1:0]        ch_en,
  output logic [1:0]        chg_keep,
  output logic              lh_stat,
  output logic              reg_wr_en
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WD_CYCLES - 1);
  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [1:0]    req_sync, dflt_sync;
  logic          limp_q;
  logic [CW-1:0] wd_cnt;
  logic          clr_wr, exit_now, wd_expired;
  logic [1:0]    safe_pat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_sync  <= '0;
      dflt_sync <= '0;
    end else begin
      req_sync  <= {req_sync[0], req_pin};
      dflt_sync <= {dflt_sync[0], dflt_pin};
    end

  assign clr_wr     = spi_strobe & spi_wr & (spi_addr == STAT_A) & ((spi_data & STAT_MASK) != '0);
  assign exit_now   = limp_q & clr_wr & ~req_sync[1];
  assign wd_expired = ~limp_q & ~spi_strobe & (wd_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      wd_cnt <= RELOAD;
    else if (spi_strobe || exit_now)
      wd_cnt <= RELOAD;
    else if (!limp_q && wd_cnt != '0)
      wd_cnt <= wd_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      limp_q <= 1'b0;
    else if (!limp_q)
      limp_q <= req_sync[1] | wd_expired;
    else if (exit_now)
      limp_q <= 1'b0;

  assign safe_pat  = (lh_field == 2'b00) ? {2{dflt_sync[1]}} : lh_field;
  assign ch_en     = limp_q ? safe_pat : cmd_on;
  assign chg_keep  = chg_busy & ch_en;
  assign lh_stat   = limp_q;
  assign reg_wr_en = spi_strobe & spi_wr & ~limp_q;
endmodule

// File: rtl/limp_home_ctrl_chk.sv
module limp_home_ctrl_chk #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int STAT_ADDR = 12,
  parameter int STAT_BIT  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_strobe,
  input logic              spi_wr,
  input logic [ADDR_W-1:0] spi_addr,
  input logic [DATA_W-1:0] spi_data,
  input logic [1:0]        lh_field,
  input logic [1:0]        cmd_on,
  input logic [1:0]        chg_busy,
  input logic [1:0]        ch_en,
  input logic [1:0]        chg_keep,
  input logic              lh_stat,
  input logic              reg_wr_en
);
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lh_stat |-> !reg_wr_en); // R6
  AST_EXIT_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lh_stat) |-> $past(spi_strobe && spi_wr && spi_addr == ADDR_W'(STAT_ADDR) && spi_data[STAT_BIT])); // R7
  AST_FIELD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (lh_stat && lh_field == 2'b11) |-> ch_en == 2'b11); // R4
  AST_FIELD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lh_stat && lh_field == 2'b01) |-> ch_en == 2'b01); // R4
  AST_KEEP_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_keep & ~ch_en) == 2'b00); // R9
  AST_KEEP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_keep & ~chg_busy) == 2'b00); // R9
  AST_ACTIVE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !lh_stat |-> ch_en == cmd_on); // R11
endmodule

bind limp_home_ctrl limp_home_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_strobe(spi_strobe), .spi_wr(spi_wr),
  .spi_addr(spi_addr), .spi_data(spi_data), .lh_field(lh_field), .cmd_on(cmd_on),
  .chg_busy(chg_busy), .ch_en(ch_en), .chg_keep(chg_keep), .lh_stat(lh_stat),
  .reg_wr_en(reg_wr_en)
);

// File: tb/limp_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module limp_home_ctrl_tb_top;
  localparam int WD = 40;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int SA = 12;
  localparam int SB = 7;

  logic clk = 1'b0, rst_n = 1'b0, req_pin = 1'b0, dflt_pin = 1'b0;
  logic spi_strobe = 1'b0, spi_wr = 1'b0;
  logic [AW-1:0] spi_addr = '0;
  logic [DW-1:0] spi_data = '0;
  logic [1:0] lh_field = 2'b00, cmd_on = 2'b00, chg_busy = 2'b00;
  logic [1:0] ch_en, chg_keep;
  logic lh_stat, reg_wr_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  limp_home_ctrl #(.WD_CYCLES(WD), .ADDR_W(AW), .DATA_W(DW), .STAT_ADDR(SA), .STAT_BIT(SB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_pin(req_pin), .dflt_pin(dflt_pin),
    .spi_strobe(spi_strobe), .spi_wr(spi_wr), .spi_addr(spi_addr), .spi_data(spi_data),
    .lh_field(lh_field), .cmd_on(cmd_on), .chg_busy(chg_busy),
    .ch_en(ch_en), .chg_keep(chg_keep), .lh_stat(lh_stat), .reg_wr_en(reg_wr_en));

  // {field, dflt, cmd, busy, exp_en, exp_keep}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {2'b01, 1'b0, 2'b00, 2'b00, 2'b01, 2'b00},
    {2'b10, 1'b0, 2'b11, 2'b00, 2'b10, 2'b00},
    {2'b11, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00},
    {2'b00, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00},
    {2'b00, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00},
    {2'b11, 1'b0, 2'b00, 2'b11, 2'b11, 2'b11},
    {2'b01, 1'b0, 2'b11, 2'b11, 2'b01, 2'b01},
    {2'b10, 1'b1, 2'b00, 2'b01, 2'b10, 2'b00},
    {2'b00, 1'b1, 2'b00, 2'b10, 2'b11, 2'b10},
    {2'b00, 1'b0, 2'b11, 2'b11, 2'b00, 2'b00}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string req, input logic exp_we);
    spi_strobe = 1'b1; spi_wr = wr; spi_addr = a; spi_data = d;
    #1 chk(req, {3'b0, reg_wr_en}, {3'b0, exp_we});
    @(negedge clk);
    spi_strobe = 1'b0; spi_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1'b1;
  end

  initial begin
    cmd_on = 2'b10;
    cyc(3);
    #1 chk("R1 stat in reset", {3'b0, lh_stat}, 4'h0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 stat after reset", {3'b0, lh_stat}, 4'h0);
    chk("R11 active follow", {2'b0, ch_en}, {2'b0, 2'b10});
    cmd_on = 2'b01; chg_busy = 2'b11;
    #1 chk("R11 active follow 01", {2'b0, ch_en}, 4'h1);
    chk("R9 keep active", {2'b0, chg_keep}, 4'h1);
    chg_busy = 2'b00;
    cyc(1);
    frame(1'b1, 6'd3, 8'h55, "R6 write passes active", 1'b1);
    frame(1'b0, 6'd3, 8'h55, "R6 read no write", 1'b0);

    req_pin = 1'b1;
    cyc(2);
    chk("R2 not yet after 2 edges", {3'b0, lh_stat}, 4'h0);
    cyc(1);
    chk("R2 entered on 3rd edge", {3'b0, lh_stat}, 4'h1);

    for (int i = 0; i < NV; i++) begin
      {lh_field, dflt_pin, cmd_on, chg_busy} = VEC[i][10:4];
      cyc(3);
      chk($sformatf("R4 R5 R9 en vec %0d", i), {2'b0, ch_en}, {2'b0, VEC[i][3:2]});
      chk($sformatf("R9 keep vec %0d", i), {2'b0, chg_keep}, {2'b0, VEC[i][1:0]});
    end
    chg_busy = 2'b00;

    frame(1'b1, 6'd3, 8'hff, "R6 write blocked", 1'b0);
    frame(1'b1, 6'(SA), 8'h80, "R8 clear write blocked", 1'b0);
    chk("R8 stays with pin high", {3'b0, lh_stat}, 4'h1);
    req_pin = 1'b0;
    cyc(4);
    frame(1'b1, 6'(SA), 8'h7f, "R7 bit clear write", 1'b0);
    chk("R7 bit zero no exit", {3'b0, lh_stat}, 4'h1);
    frame(1'b1, 6'(SA - 1), 8'h80, "R7 wrong addr write", 1'b0);
    chk("R7 wrong addr no exit", {3'b0, lh_stat}, 4'h1);
    cmd_on = 2'b10;
    frame(1'b1, 6'(SA), 8'h80, "R7 exit write", 1'b0);
    chk("R7 exit", {3'b0, lh_stat}, 4'h0);
    chk("R11 follow after exit", {2'b0, ch_en}, 4'h2);

    cyc(WD - 3);
    chk("R10 reloaded on exit", {3'b0, lh_stat}, 4'h0);
    frame(1'b0, 6'd0, 8'h00, "R6 kick read", 1'b0);
    cyc(WD - 3);
    chk("R3 reload by strobe", {3'b0, lh_stat}, 4'h0);
    cyc(4);
    chk("R3 timeout entry", {3'b0, lh_stat}, 4'h1);

    cyc(3 * WD);
    chk("R10 held in limp", {3'b0, lh_stat}, 4'h1);
    frame(1'b1, 6'(SA), 8'h80, "R7 exit after timeout", 1'b0);
    chk("R7 exit after timeout", {3'b0, lh_stat}, 4'h0);
    cyc(WD - 3);
    chk("R10 full window after exit", {3'b0, lh_stat}, 4'h0);
    cyc(4);
    chk("R3 second timeout", {3'b0, lh_stat}, 4'h1);

    rst_n = 1'b0;
    #1 chk("R1 reset clears limp", {3'b0, lh_stat}, 4'h0);
    cyc(2);
    rst_n = 1'b1;
    cyc(WD - 3);
    chk("R1 full count after reset", {3'b0, lh_stat}, 4'h0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule